// File: doc/BRIEF.md
# Trace Monitor Pattern Matcher

This block watches a 64-bit data word that arrives with a valid strobe and does three things with every accepted word. It decides whether the word is collected into the trace stream. It compares the word against a masked trigger pattern and pulses a trigger output on a match. It compares the word against a second, independent masked pattern and pulses a timestamp request on a match, but only while pattern timestamping is switched on.

Collection has two modes. In continuous mode every valid word is collected. In trace-on-change mode a word is collected only when it differs from the previous valid word seen while the unit was enabled. All configuration sits in 32-bit registers on a simple word-addressed write/read bus. Each 64-bit pattern and mask is held as two words: word 0 holds data bits 31:0 and word 1 holds bits 63:32.

Top module: `trace_pattern_monitor`

## Requirements
- R1: After reset, `cap_valid`, `trig_out` and `ts_req` are low, and every mapped register reads zero.
- R2: Register map, by word address: 0x280 control, with bit 0 the unit enable and bit 1 the collection mode (0 continuous, 1 trace-on-change). 0x281 timestamp enable in bit 0. 0x282/0x283 timestamp pattern words 0/1. 0x284/0x285 timestamp mask words 0/1. 0x286/0x287 trigger pattern words 0/1. 0x288/0x289 trigger mask words 0/1. Every register reads back its last written value. Only bits 1:0 of control and bit 0 of timestamp enable are stored; their other bits read zero.
- R3: A write to any other word address changes no register. A read from any other address returns zero.
- R4: While the enable bit is clear, no capture, trigger or timestamp pulse is produced. Clearing the enable also discards the previous-sample history.
- R5: In continuous mode with the unit enabled, every valid word raises `cap_valid` on the next cycle, and `cap_data` then holds that word.
- R6: In trace-on-change mode, a valid word is captured only if it differs from the previous valid word seen while enabled. The first valid word after enabling is always captured.
- R7: A mask bit of 1 compares the data bit with the same-index pattern bit. A mask bit of 0 makes that bit don't-care. Both 32-bit halves must agree for a match, so an all-zero mask matches every word.
- R8: With the unit enabled, every valid word that matches the trigger pattern gives a `trig_out` pulse, whether or not it is captured.
- R9: `ts_req` pulses for a valid word that matches the timestamp pattern only while timestamp enable bit 0 is set.
- R10: All three outputs are single-cycle pulses, registered one cycle after the valid input, and low in any cycle that follows a cycle without a valid input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| din_valid | input | 1 | Input data valid |
| din | input | 64 | Monitored data word |
| cap_valid | output | 1 | Captured word strobe |
| cap_data | output | 64 | Captured word |
| trig_out | output | 1 | Trigger pattern match pulse |
| ts_req | output | 1 | Timestamp request pulse |

## Verification
The assertions assume that `din` and `din_valid` are stable through each clock edge. They also assume that reset is held for at least one edge before any property is evaluated, so `$past` terms only ever see reset-time zeros. The stimulus changes every input only on the falling edge and holds reset for several cycles. It interleaves register writes with data cycles, so a configuration change takes effect on the first data word driven after it. That matches the ordering the checker relies on when it relates a pulse to the enable and mode of the previous cycle.

// File: rtl/tpm_pkg.sv
// Package: shared constants and types for the trace pattern monitor.
// Assumes word-addressed registers; the bank layout is derived from NWORDS.
package tpm_pkg;
    localparam int ADDR_W = 10;
    localparam logic [ADDR_W-1:0] A_CTRL  = 10'h280;
    localparam logic [ADDR_W-1:0] A_TSEN  = 10'h281;
    localparam logic [ADDR_W-1:0] A_BANK0 = 10'h282;
    localparam int NBANKS = 4;   // ts pattern, ts mask, trig pattern, trig mask

    typedef enum logic {
        MODE_CONT = 1'b0,
        MODE_TOC  = 1'b1
    } cap_mode_e;
endpackage

// File: rtl/tpm_regfile.sv
// Module: configuration registers of the monitor.
// Holds the control bits, the timestamp enable and four banks of NWORDS
// words (ts pattern, ts mask, trig pattern, trig mask), laid out back to back
// from A_BANK0. Unmapped writes are dropped and unmapped reads return zero.
module tpm_regfile
    import tpm_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int NWORDS = 2,
    localparam int DATA_W = REG_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              en,
    output cap_mode_e         mode,
    output logic              ts_en,
    output logic [DATA_W-1:0] ts_pat,
    output logic [DATA_W-1:0] ts_msk,
    output logic [DATA_W-1:0] tr_pat,
    output logic [DATA_W-1:0] tr_msk
);
    logic [1:0]       ctrl_q;
    logic             tsen_q;
    logic [REG_W-1:0] bank_q [NBANKS][NWORDS];

    function automatic logic [ADDR_W-1:0] bank_addr(input int b, input int k);
        return A_BANK0 + ADDR_W'(b * NWORDS + k);
    endfunction

    // Register writes with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tsen_q <= 1'b0;
            for (int b = 0; b < NBANKS; b++)
                for (int k = 0; k < NWORDS; k++)
                    bank_q[b][k] <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl_q <= wdata[1:0];
            if (addr == A_TSEN) tsen_q <= wdata[0];
            for (int b = 0; b < NBANKS; b++)
                for (int k = 0; k < NWORDS; k++)
                    if (addr == bank_addr(b, k)) bank_q[b][k] <= wdata;
        end
    end

    // Read multiplexer; unmatched addresses leave zero.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) rdata[1:0] = ctrl_q;
        if (addr == A_TSEN) rdata[0]   = tsen_q;
        for (int b = 0; b < NBANKS; b++)
            for (int k = 0; k < NWORDS; k++)
                if (addr == bank_addr(b, k)) rdata = bank_q[b][k];
    end

    assign en    = ctrl_q[0];
    assign mode  = cap_mode_e'(ctrl_q[1]);
    assign ts_en = tsen_q;

    // Word k of each bank drives data bits [k*REG_W +: REG_W].
    for (genvar k = 0; k < NWORDS; k++) begin : g_flat
        assign ts_pat[k*REG_W +: REG_W] = bank_q[0][k];
        assign ts_msk[k*REG_W +: REG_W] = bank_q[1][k];
        assign tr_pat[k*REG_W +: REG_W] = bank_q[2][k];
        assign tr_msk[k*REG_W +: REG_W] = bank_q[3][k];
    end
endmodule

// File: rtl/tpm_mask_cmp.sv
// Module: masked equality comparator.
// A mask bit of 1 makes that bit count; 0 makes it don't-care. Purely combinational.
module tpm_mask_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] msk,
    output logic         hit
);
    // Any compared bit that differs breaks the match.
    assign hit = ~|((data ^ pat) & msk);
endmodule

// File: rtl/tpm_capture.sv
// Module: collection and pulse stage.
// Registers the capture strobe and data, the trigger pulse and the timestamp
// pulse one cycle after a valid input. Keeps the previous sample for
// trace-on-change mode; the history is dropped whenever the unit is disabled.
module tpm_capture
    import tpm_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  cap_mode_e    mode,
    input  logic         din_valid,
    input  logic [W-1:0] din,
    input  logic         trig_hit,
    input  logic         ts_hit,
    output logic         cap_valid,
    output logic [W-1:0] cap_data,
    output logic         trig_out,
    output logic         ts_req
);
    logic [W-1:0] prev_q;
    logic         have_q;
    logic         accept;
    logic         take;

    // Decide acceptance and whether the word is collected in this mode.
    always_comb begin
        accept = en && din_valid;
        take   = accept && (mode == MODE_CONT || !have_q || din != prev_q);
    end

    // Output pulses, captured word and previous-sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_data  <= '0;
            trig_out  <= 1'b0;
            ts_req    <= 1'b0;
            prev_q    <= '0;
            have_q    <= 1'b0;
        end else begin
            cap_valid <= take;
            trig_out  <= accept && trig_hit;
            ts_req    <= accept && ts_hit;
            if (take) cap_data <= din;
            if (!en) begin
                have_q <= 1'b0;
            end else if (din_valid) begin
                have_q <= 1'b1;
                prev_q <= din;
            end
        end
    end
endmodule

// File: rtl/trace_pattern_monitor.sv
// Module: top of the trace monitor pattern matcher.
// Ties the register file to two masked comparators (timestamp, trigger) and the
// capture stage. Assumes DATA_W = REG_W * NWORDS.
module trace_pattern_monitor
    import tpm_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int NWORDS = 2,
    localparam int DATA_W = REG_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              din_valid,
    input  logic [DATA_W-1:0] din,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data,
    output logic              trig_out,
    output logic              ts_req
);
    localparam int NCMP = 2;   // 0: timestamp, 1: trigger

    logic              cfg_en;
    cap_mode_e         cfg_mode;
    logic              cfg_ts_en;
    logic [DATA_W-1:0] cmp_pat [NCMP];
    logic [DATA_W-1:0] cmp_msk [NCMP];
    logic [NCMP-1:0]   cmp_hit;

    tpm_regfile #(.REG_W(REG_W), .NWORDS(NWORDS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .en     (cfg_en),
        .mode   (cfg_mode),
        .ts_en  (cfg_ts_en),
        .ts_pat (cmp_pat[0]),
        .ts_msk (cmp_msk[0]),
        .tr_pat (cmp_pat[1]),
        .tr_msk (cmp_msk[1])
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        tpm_mask_cmp #(.W(DATA_W)) u_cmp (
            .data (din),
            .pat  (cmp_pat[g]),
            .msk  (cmp_msk[g]),
            .hit  (cmp_hit[g])
        );
    end

    tpm_capture #(.W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .mode      (cfg_mode),
        .din_valid (din_valid),
        .din       (din),
        .trig_hit  (cmp_hit[1]),
        .ts_hit    (cmp_hit[0] && cfg_ts_en),
        .cap_valid (cap_valid),
        .cap_data  (cap_data),
        .trig_out  (trig_out),
        .ts_req    (ts_req)
    );
endmodule

// File: rtl/tpm_checker.sv
// Module: temporal checks on the pattern monitor, attached by bind.
// Assumes inputs change away from the clock edge and reset is held at start.
module tpm_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         din_valid,
    input logic [W-1:0] din,
    input logic         cfg_en,
    input logic         cfg_mode,
    input logic         cfg_ts_en,
    input logic         cap_valid,
    input logic [W-1:0] cap_data,
    input logic         trig_out,
    input logic         ts_req
);
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !(cap_valid || trig_out || ts_req)); // R4

    AST_CONT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_mode && din_valid) |=> cap_valid); // R5

    AST_CAP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> cap_data == $past(din)); // R5

    AST_TOC_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_mode && din_valid && $past(cfg_en) && $past(din_valid)
         && din == $past(din)) |=> !cap_valid); // R6

    AST_TS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ts_req |-> $past(cfg_ts_en)); // R9

    AST_PULSE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid || trig_out || ts_req) |-> $past(din_valid)); // R10
endmodule

bind trace_pattern_monitor tpm_checker #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_valid (din_valid),
    .din       (din),
    .cfg_en    (cfg_en),
    .cfg_mode  (cfg_mode),
    .cfg_ts_en (cfg_ts_en),
    .cap_valid (cap_valid),
    .cap_data  (cap_data),
    .trig_out  (trig_out),
    .ts_req    (ts_req)
);

// File: tb/trace_pattern_monitor_bench.sv
`timescale 1ns/1ps
// Directed bench: a shadow model predicts every output cycle from the requirements.
module trace_pattern_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        din_valid = 1'b0;
    logic [63:0] din = '0;
    logic        cap_valid;
    logic [63:0] cap_data;
    logic        trig_out;
    logic        ts_req;

    int n_checks = 0;
    int n_fail   = 0;
    string scen = "R1 reset";

    // shadow configuration and expectations
    logic [1:0]  m_ctrl = '0;
    logic        m_tsen = 1'b0;
    logic [63:0] m_tsp = '0, m_tsm = '0, m_trp = '0, m_trm = '0;
    logic [63:0] m_prev = '0;
    logic        m_have = 1'b0;
    logic        e_cap = 1'b0, e_trig = 1'b0, e_ts = 1'b0;
    logic [63:0] e_data = '0;

    always #2.5 clk = ~clk;

    trace_pattern_monitor u_trace_pattern_monitor (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .din_valid(din_valid),
        .din(din), .cap_valid(cap_valid), .cap_data(cap_data),
        .trig_out(trig_out), .ts_req(ts_req)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL [%s] %s actual=%h expected=%h", scen, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk("cap_valid", 64'(cap_valid), 64'(e_cap));
        chk("trig_out",  64'(trig_out),  64'(e_trig));
        chk("ts_req",    64'(ts_req),    64'(e_ts));
        if (e_cap) chk("cap_data", cap_data, e_data);
    endtask

    function automatic logic [31:0] rd_model(input logic [9:0] a);
        case (a)
            10'h280: return {30'd0, m_ctrl};
            10'h281: return {31'd0, m_tsen};
            10'h282: return m_tsp[31:0];
            10'h283: return m_tsp[63:32];
            10'h284: return m_tsm[31:0];
            10'h285: return m_tsm[63:32];
            10'h286: return m_trp[31:0];
            10'h287: return m_trp[63:32];
            10'h288: return m_trm[31:0];
            10'h289: return m_trm[63:32];
            default: return 32'd0;
        endcase
    endfunction

    // One data cycle: check the previous cycle's outputs, then drive and predict.
    task automatic step(input logic v, input logic [63:0] d);
        @(negedge clk);
        check_outputs();
        reg_wr_en = 1'b0;
        din_valid = v;
        din = d;
        e_cap  = m_ctrl[0] && v && (!m_ctrl[1] || !m_have || d != m_prev);
        e_trig = m_ctrl[0] && v && (((d ^ m_trp) & m_trm) == 64'd0);
        e_ts   = m_ctrl[0] && v && m_tsen && (((d ^ m_tsp) & m_tsm) == 64'd0);
        e_data = d;
        if (m_ctrl[0] && v) begin
            m_have = 1'b1;
            m_prev = d;
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] wd);
        @(negedge clk);
        check_outputs();
        din_valid = 1'b0;
        reg_wr_en = 1'b1;
        reg_addr = a;
        reg_wdata = wd;
        e_cap = 1'b0; e_trig = 1'b0; e_ts = 1'b0;
        case (a)
            10'h280: begin m_ctrl = wd[1:0]; if (!wd[0]) m_have = 1'b0; end
            10'h281: m_tsen = wd[0];
            10'h282: m_tsp[31:0]  = wd;
            10'h283: m_tsp[63:32] = wd;
            10'h284: m_tsm[31:0]  = wd;
            10'h285: m_tsm[63:32] = wd;
            10'h286: m_trp[31:0]  = wd;
            10'h287: m_trp[63:32] = wd;
            10'h288: m_trm[31:0]  = wd;
            10'h289: m_trm[63:32] = wd;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [9:0] a);
        @(negedge clk);
        check_outputs();
        din_valid = 1'b0;
        reg_wr_en = 1'b0;
        reg_addr = a;
        e_cap = 1'b0; e_trig = 1'b0; e_ts = 1'b0;
        #1;
        chk($sformatf("rdata@%h", a), 64'(reg_rdata), 64'(rd_model(a)));
    endtask

    task automatic wr64(input logic [9:0] a, input logic [63:0] v);
        wr(a, v[31:0]);
        wr(a + 10'd1, v[63:32]);
    endtask

    task automatic read_all();
        for (int a = 10'h27E; a <= 10'h28B; a++) rd(10'(a));
    endtask

    task automatic t_reset();
        scen = "R1 reset";
        read_all();
    endtask

    task automatic t_regs();
        scen = "R2 readback";
        wr(10'h280, 32'hFFFF_FFFE);
        wr(10'h281, 32'hFFFF_FFFE);
        wr64(10'h282, 64'h0123_4567_89AB_CDEF);
        wr64(10'h284, 64'hFEDC_BA98_7654_3210);
        wr64(10'h286, 64'hA5A5_0F0F_5A5A_F0F0);
        wr64(10'h288, 64'h1111_2222_3333_4444);
        read_all();
        wr(10'h281, 32'h0000_0001);
        rd(10'h281);
        scen = "R3 unmapped";
        wr(10'h28A, 32'hDEAD_BEEF);
        wr(10'h27F, 32'hCAFE_F00D);
        wr(10'h000, 32'hFFFF_FFFF);
        wr(10'h3FF, 32'hFFFF_FFFF);
        read_all();
        rd(10'h000);
        rd(10'h3FF);
        scen = "R2 clear";
        wr(10'h280, 32'h0); wr(10'h281, 32'h0);
        wr64(10'h282, 64'h0); wr64(10'h284, 64'h0);
        wr64(10'h286, 64'h0); wr64(10'h288, 64'h0);
        read_all();
    endtask

    task automatic t_off();
        scen = "R4 disabled";
        wr(10'h281, 32'h1);
        wr(10'h280, 32'h2);
        step(1, 64'h1); step(1, 64'h2); step(1, 64'h2); step(0, 64'h0);
        wr(10'h280, 32'h0);
        step(1, 64'h3); step(0, 64'h0);
    endtask

    task automatic t_cont();
        scen = "R5 continuous";
        wr(10'h280, 32'h1);
        step(1, 64'hAAAA_0000_5555_1111);
        step(1, 64'hAAAA_0000_5555_1111);
        step(1, 64'hAAAA_0000_5555_1111);
        scen = "R10 pulse";
        step(0, 64'hAAAA_0000_5555_1111);
        step(0, 64'h0);
        step(1, 64'h0000_0000_0000_0007);
        step(0, 64'h0);
    endtask

    task automatic t_toc();
        scen = "R6 trace-on-change";
        wr(10'h280, 32'h0);
        wr(10'h280, 32'h3);
        step(1, 64'hA); step(1, 64'hA); step(1, 64'hB); step(1, 64'hB);
        step(1, 64'hA); step(0, 64'h0); step(1, 64'hA); step(1, 64'hC);
        scen = "R4 history cleared";
        wr(10'h280, 32'h0);
        wr(10'h280, 32'h3);
        step(1, 64'hC); step(1, 64'hC); step(0, 64'h0);
    endtask

    task automatic t_mask();
        scen = "R7 mask";
        wr(10'h280, 32'h1);
        wr64(10'h286, 64'h1234_5678_9ABC_DEF0);
        wr64(10'h288, 64'hFF00_0000_0000_FFFF);
        step(1, 64'h1234_5678_9ABC_DEF0);
        step(1, 64'h12FF_FFFF_FFFF_DEF0);
        step(1, 64'h1234_5678_9ABC_DEF1);
        step(1, 64'h1334_5678_9ABC_DEF0);
        step(0, 64'h0);
        scen = "R8 trigger on repeat";
        wr(10'h280, 32'h3);
        step(1, 64'h1234_0000_0000_DEF0);
        step(1, 64'h1234_0000_0000_DEF0);
        step(1, 64'h1234_0000_0000_DEF0);
        step(0, 64'h0);
        wr(10'h280, 32'h0);
    endtask

    task automatic t_ts();
        scen = "R9 timestamp gate";
        wr64(10'h282, 64'h0000_00FF_0000_0000);
        wr64(10'h284, 64'h0000_00FF_0000_000F);
        wr(10'h281, 32'h0);
        wr(10'h280, 32'h1);
        step(1, 64'h0000_00FF_1234_5670);
        step(0, 64'h0);
        wr(10'h281, 32'h1);
        step(1, 64'h0000_00FF_1234_5670);
        step(1, 64'hFFFF_00FF_FFFF_FFF0);
        step(1, 64'h0000_00FE_1234_5670);
        step(1, 64'h0000_00FF_1234_5671);
        step(0, 64'h0);
        step(0, 64'h0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL [watchdog] run did not finish actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_off();
        t_cont();
        t_toc();
        t_mask();
        t_ts();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule